// File: doc/BRIEF.md
# Signed/Unsigned 64-by-32 Sequential Divider

This block divides a 64-bit dividend, presented as a high and a low word, by a 32-bit divisor. It returns a 32-bit quotient, a 32-bit remainder and five condition flags. A mode input selects two's-complement or unsigned operation. A caller raises `start` for one cycle with the operands applied. It then waits for the one-cycle `done` pulse, and the results stay on the outputs until the next completed operation.

In signed mode, negative operands are first turned into magnitudes. The dividend is negated as a two-word value, with the borrow carried from the low word into the high word. The two sign bits are kept for the final step. Three cases finish one cycle after `start`:
- a zero divisor, which raises an error pulse and produces no result;
- a quotient that cannot fit in 32 bits, which is reported as overflow;
- a dividend whose magnitude is below the divisor.

Every other division runs a restoring shift-subtract loop that yields one quotient bit per clock. The signs are restored afterwards, and the signed quotient range is checked.

The flags are packed as a 5-bit vector, from bit 4 down to bit 0: X (extend), N (negative), Z (zero), V (overflow), C (carry).

Top module: `wide_divider`

## Requirements
- R1: A `start` with a zero divisor produces no result. `div_zero` is high for exactly one cycle, in the cycle after `start` is sampled. `done` and `busy` stay low. `quotient`, `remainder` and `flags_out` keep their previous values.
- R2: Unsigned division with a nonzero divisor and a 32-bit quotient gives quotient = floor(dividend / divisor) and remainder = dividend mod divisor. When the loop is needed, `done` rises 33 clock edges after the edge that samples `start` (one edge to load, 32 loop edges, one edge to finish).
- R3: In signed mode the quotient and remainder are computed from the operand magnitudes. The remainder takes the sign of the dividend. The quotient is negated when the two operand signs differ.
- R4: A dividend of zero gives quotient 0 and remainder 0, with Z set. `done` rises on the first edge after the edge that samples `start`.
- R5: When the high word of the dividend magnitude is zero and the divisor magnitude is greater than its low word, the quotient is 0. The remainder is the low magnitude word, with the dividend's sign in signed mode. `done` rises on the first edge after `start`.
- R6: When the high word of the dividend magnitude is greater than or equal to the divisor magnitude, the result is overflow. `remainder` returns the original high dividend word and `quotient` returns the original low word. In `flags_out`, X, N and Z are copied from `flags_in`, V (bit 1) is 1 and C (bit 0) is 0. `done` rises on the first edge after `start`.
- R7: In signed mode, a negative quotient whose magnitude exceeds 0x80000000 is overflow. So is a positive quotient with bit 31 set. Either case gives the same outputs as R6, after the full loop latency.
- R8: On a completion without overflow, X (bit 4) is copied from `flags_in`. N (bit 3) equals quotient bit 31. Z (bit 2) is set exactly when the quotient is zero. V and C are 0.
- R9: `done` is high for exactly one cycle per accepted operation. `busy` is high from the cycle after `start` until the cycle in which `done` is high, and it is low in that cycle.
- R10: `start` is ignored while `busy` is high. The results and flags change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled while idle |
| signed_mode | input | 1 | 1 = two's-complement, 0 = unsigned |
| dividend_hi | input | 32 | Upper word of the dividend |
| dividend_lo | input | 32 | Lower word of the dividend |
| divisor | input | 32 | Divisor |
| flags_in | input | 5 | Incoming flags {X,N,Z,V,C} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | One-cycle pulse on a zero divisor |
| quotient | output | 32 | Quotient, or original low dividend word on overflow |
| remainder | output | 32 | Remainder, or original high dividend word on overflow |
| flags_out | output | 5 | Result flags {X,N,Z,V,C} |

## Verification
The datapath registers are visible only when `done` rises, so an error in them shows up late. A wrong quotient bit or a lost restore step inside the loop appears at `quotient` or `remainder` only 33 cycles after `start`. A wrong path classification is visible sooner, because it moves `done` between the 1-cycle and the 33-cycle latency. A sign flag captured wrongly at `start` shows at the finish, as a wrong sign bit in the remainder or as a missed or false overflow in V. The tests therefore measure the latency of every operation as well as its values, and they place operands on each side of every path boundary.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

  localparam int FLAG_W = 5;
  localparam int FLG_C  = 0;
  localparam int FLG_V  = 1;
  localparam int FLG_Z  = 2;
  localparam int FLG_N  = 3;
  localparam int FLG_X  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } wdiv_state_e;

  function automatic logic [FLAG_W-1:0] pack_flags(
    input logic x, input logic n, input logic z, input logic v, input logic c);
    logic [FLAG_W-1:0] f;
    f        = '0;
    f[FLG_X] = x;
    f[FLG_N] = n;
    f[FLG_Z] = z;
    f[FLG_V] = v;
    f[FLG_C] = c;
    return f;
  endfunction

endpackage

// File: rtl/wdiv_prep.sv
module wdiv_prep #(
  parameter int W = 32
) (
  input  logic         signed_mode,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] hi_mag,
  output logic [W-1:0] lo_mag,
  output logic [W-1:0] dvs_mag,
  output logic         neg_dvd,
  output logic         neg_dvs,
  output logic         dvs_zero,
  output logic         ovf_early,
  output logic         short_path
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // Two-word negate: the low word's carry out feeds the high word
  function automatic logic [2*W-1:0] neg_pair(input logic [W-1:0] hi, input logic [W-1:0] lo);
    logic [W:0]   lo_sum;
    logic [W-1:0] hi_n;
    lo_sum = {1'b0, ~lo} + {1'b0, ONE};
    hi_n   = ~hi + {{(W-1){1'b0}}, lo_sum[W]};
    return {hi_n, lo_sum[W-1:0]};
  endfunction

  function automatic logic [W-1:0] neg_word(input logic [W-1:0] v);
    return ~v + ONE;
  endfunction

  logic [2*W-1:0] dvd_neg;

  always_comb begin
    neg_dvd  = signed_mode & dvd_hi[W-1];
    neg_dvs  = signed_mode & dvs[W-1];
    dvd_neg  = neg_pair(dvd_hi, dvd_lo);
    hi_mag   = neg_dvd ? dvd_neg[2*W-1:W] : dvd_hi;
    lo_mag   = neg_dvd ? dvd_neg[W-1:0]   : dvd_lo;
    dvs_mag  = neg_dvs ? neg_word(dvs)    : dvs;
    dvs_zero = (dvs == '0);
  end

  // The quotient fits only when the high magnitude word is below the divisor
  assign ovf_early  = (hi_mag >= dvs_mag);
  assign short_path = (hi_mag == '0) && (dvs_mag > lo_mag);

endmodule

// File: rtl/wdiv_core.sv
module wdiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] rem_init,
  input  logic [W-1:0] quo_init,
  input  logic [W-1:0] dvs_init,
  input  logic         step,
  output logic [W-1:0] rem_q,
  output logic [W-1:0] quo_q,
  output logic         last_step
);

  localparam int           CW   = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic [2*W-1:0] nxt;

  // One restoring step: shift the pair left, subtract when it fits
  function automatic logic [2*W-1:0] restore_step(
    input logic [W-1:0] rem, input logic [W-1:0] quo, input logic [W-1:0] d);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;
    trial = {rem, quo[W-1]};
    diff  = trial - {1'b0, d};
    fits  = (trial >= {1'b0, d});
    return {(fits ? diff[W-1:0] : trial[W-1:0]), quo[W-2:0], fits};
  endfunction

  assign nxt       = restore_step(rem_q, quo_q, dvs_q);
  assign last_step = step && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      rem_q <= rem_init;
      quo_q <= quo_init;
      dvs_q <= dvs_init;
      cnt_q <= '0;
    end else if (step) begin
      rem_q <= nxt[2*W-1:W];
      quo_q <= nxt[W-1:0];
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (rem_q < dvs_q)); // R2

  AST_STEP_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step && (cnt_q == LAST) |=> !step); // R2

endmodule

// File: rtl/wdiv_fix.sv
module wdiv_fix #(
  parameter int W = 32
) (
  input  logic         signed_mode,
  input  logic         neg_dvd,
  input  logic         neg_dvs,
  input  logic [W-1:0] qmag,
  input  logic [W-1:0] rmag,
  output logic [W-1:0] q_fix,
  output logic [W-1:0] r_fix,
  output logic         range_ovf
);

  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] negate(input logic [W-1:0] v);
    return ~v + ONE;
  endfunction

  logic q_negative;

  always_comb begin
    q_negative = neg_dvd ^ neg_dvs;
    r_fix      = neg_dvd ? negate(rmag) : rmag;
    q_fix      = q_negative ? negate(qmag) : qmag;
    if (!signed_mode)     range_ovf = 1'b0;
    else if (q_negative)  range_ovf = (qmag > MIN_NEG);
    else                  range_ovf = qmag[W-1];
  end

endmodule

// File: rtl/wide_divider.sv
module wide_divider
  import wdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              signed_mode,
  input  logic [W-1:0]      dividend_hi,
  input  logic [W-1:0]      dividend_lo,
  input  logic [W-1:0]      divisor,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              busy,
  output logic              done,
  output logic              div_zero,
  output logic [W-1:0]      quotient,
  output logic [W-1:0]      remainder,
  output logic [FLAG_W-1:0] flags_out
);

  wdiv_state_e state_q;

  logic [W-1:0] hi_mag, lo_mag, dvs_mag;
  logic         neg_dvd, neg_dvs, dvs_zero, ovf_early, short_path;
  logic         accept, core_load, core_step, last_step;
  logic [W-1:0] rem_core, quo_core;
  logic [W-1:0] q_fix, r_fix;
  logic         range_ovf, final_ovf;

  logic         mode_q, neg_dvd_q, neg_dvs_q, ovf_q;
  logic [W-1:0] orig_hi_q, orig_lo_q;
  logic         x_q, n_q, z_q;
  logic         done_q, dz_q;
  logic         vc_unused;

  assign vc_unused = flags_in[FLG_V] ^ flags_in[FLG_C];

  wdiv_prep #(.W(W)) u_prep (
    .signed_mode (signed_mode),
    .dvd_hi      (dividend_hi),
    .dvd_lo      (dividend_lo),
    .dvs         (divisor),
    .hi_mag      (hi_mag),
    .lo_mag      (lo_mag),
    .dvs_mag     (dvs_mag),
    .neg_dvd     (neg_dvd),
    .neg_dvs     (neg_dvs),
    .dvs_zero    (dvs_zero),
    .ovf_early   (ovf_early),
    .short_path  (short_path)
  );

  assign accept    = (state_q == ST_IDLE) && start;
  assign core_load = accept && !dvs_zero;
  assign core_step = (state_q == ST_RUN);

  wdiv_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (core_load),
    .rem_init  (short_path ? lo_mag : hi_mag),
    .quo_init  (short_path ? '0 : lo_mag),
    .dvs_init  (dvs_mag),
    .step      (core_step),
    .rem_q     (rem_core),
    .quo_q     (quo_core),
    .last_step (last_step)
  );

  wdiv_fix #(.W(W)) u_fix (
    .signed_mode (mode_q),
    .neg_dvd     (neg_dvd_q),
    .neg_dvs     (neg_dvs_q),
    .qmag        (quo_core),
    .rmag        (rem_core),
    .q_fix       (q_fix),
    .r_fix       (r_fix),
    .range_ovf   (range_ovf)
  );

  assign final_ovf = ovf_q | range_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_q    <= 1'b0;
      neg_dvd_q <= 1'b0;
      neg_dvs_q <= 1'b0;
      ovf_q     <= 1'b0;
      orig_hi_q <= '0;
      orig_lo_q <= '0;
      x_q       <= 1'b0;
      n_q       <= 1'b0;
      z_q       <= 1'b0;
      done_q    <= 1'b0;
      dz_q      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      flags_out <= '0;
    end else begin
      done_q <= 1'b0;
      dz_q   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (dvs_zero) begin
              dz_q <= 1'b1;
            end else begin
              mode_q    <= signed_mode;
              neg_dvd_q <= neg_dvd;
              neg_dvs_q <= neg_dvs;
              ovf_q     <= ovf_early;
              orig_hi_q <= dividend_hi;
              orig_lo_q <= dividend_lo;
              x_q       <= flags_in[FLG_X];
              n_q       <= flags_in[FLG_N];
              z_q       <= flags_in[FLG_Z];
              state_q   <= (ovf_early || short_path) ? ST_FIN : ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (last_step) state_q <= ST_FIN;
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
          if (final_ovf) begin
            quotient  <= orig_lo_q;
            remainder <= orig_hi_q;
            flags_out <= pack_flags(x_q, n_q, z_q, 1'b1, 1'b0);
          end else begin
            quotient  <= q_fix;
            remainder <= r_fix;
            flags_out <= pack_flags(x_q, q_fix[W-1], (q_fix == '0), 1'b0, 1'b0);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign div_zero = dz_q;

  AST_DZ_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> !done && !busy); // R1

  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    done && !flags_out[FLG_V] && mode_q && (remainder != '0) |-> remainder[W-1] == neg_dvd_q); // R3

  AST_OVF_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    done && flags_out[FLG_V] |-> !flags_out[FLG_C] && remainder == orig_hi_q && quotient == orig_lo_q); // R6

  AST_NORMAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !flags_out[FLG_V] |-> !flags_out[FLG_C] && (flags_out[FLG_Z] == (quotient == '0)) && (flags_out[FLG_N] == quotient[W-1])); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9

  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(quotient) && $stable(remainder) && $stable(flags_out)); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(orig_hi_q) && $stable(orig_lo_q) && $stable(mode_q)); // R10

endmodule

// File: tb/tb_wide_divider.sv
module tb_wide_divider;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [31:0] dividend_hi = '0;
  logic [31:0] dividend_lo = '0;
  logic [31:0] divisor = '0;
  logic [4:0]  flags_in = '0;
  logic        busy, done, div_zero;
  logic [31:0] quotient, remainder;
  logic [4:0]  flags_out;

  int total = 0;
  int passed = 0;

  always #5 clk = ~clk;

  wide_divider dut (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
    .flags_in(flags_in), .busy(busy), .done(done), .div_zero(div_zero),
    .quotient(quotient), .remainder(remainder), .flags_out(flags_out)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  // Reference: 64-bit magnitudes, then sign and range rules
  task automatic model(input bit sgn, input logic [31:0] hi, input logic [31:0] lo,
                       input logic [31:0] dv, input logic [4:0] fin,
                       output logic [31:0] eq, output logic [31:0] er,
                       output logic [4:0] ef, output int elat);
    logic [63:0] dvd, dmag, qm, rm;
    logic [31:0] vmag;
    bit nd, nv, ovf;
    dvd  = {hi, lo};
    nd   = sgn && hi[31];
    nv   = sgn && dv[31];
    dmag = nd ? (64'd0 - dvd) : dvd;
    vmag = nv ? (32'd0 - dv) : dv;
    qm   = dmag / {32'd0, vmag};
    rm   = dmag % {32'd0, vmag};
    ovf  = (qm > 64'h0000_0000_FFFF_FFFF);
    elat = (ovf || (dmag[63:32] == 32'd0 && vmag > dmag[31:0])) ? 1 : 33;
    eq   = qm[31:0];
    er   = rm[31:0];
    if (!ovf && sgn) begin
      if (nd) er = 32'd0 - er;
      if (nd != nv) begin
        if (qm[31:0] > 32'h8000_0000) ovf = 1'b1;
        else eq = 32'd0 - qm[31:0];
      end else if (qm[31]) ovf = 1'b1;
    end
    if (ovf) begin
      eq = lo; er = hi; ef = {fin[4:2], 2'b10};
    end else begin
      ef = {fin[4], eq[31], (eq == 32'd0), 2'b00};
    end
  endtask

  task automatic drive_start(input bit sgn, input logic [31:0] hi, input logic [31:0] lo,
                             input logic [31:0] dv, input logic [4:0] fin);
    @(negedge clk);
    signed_mode = sgn; dividend_hi = hi; dividend_lo = lo; divisor = dv; flags_in = fin;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_div(input string tag, input bit sgn, input logic [31:0] hi,
                         input logic [31:0] lo, input logic [31:0] dv, input logic [4:0] fin);
    logic [31:0] eq, er;
    logic [4:0]  ef;
    int elat, k;
    model(sgn, hi, lo, dv, fin, eq, er, ef, elat);
    drive_start(sgn, hi, lo, dv, fin);
    check(busy == 1'b1, "R9", {tag, " busy after start"}, busy, 1);
    k = 0;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    check(k == elat, tag, "latency", k, elat);
    check(busy == 1'b0, "R9", {tag, " busy low at done"}, busy, 0);
    check(quotient == eq, tag, "quotient", quotient, eq);
    check(remainder == er, tag, "remainder", remainder, er);
    check(flags_out == ef, tag, "flags", flags_out, ef);
    @(negedge clk);
    check(done == 1'b0, "R9", {tag, " done one cycle"}, done, 0);
  endtask

  task automatic test_reset();
    check(busy == 0 && done == 0 && div_zero == 0, "R9", "reset handshake", {busy, done, div_zero}, 0);
    check(quotient == 0 && remainder == 0 && flags_out == 0, "R10", "reset results",
          {quotient, remainder}, 0);
  endtask

  task automatic test_zero_divisor();
    logic [31:0] pq, pr;
    logic [4:0]  pf;
    pq = quotient; pr = remainder; pf = flags_out;
    drive_start(1'b0, 32'h1, 32'h2, 32'h0, 5'h1F);
    check(div_zero == 1'b1, "R1", "div_zero pulse", div_zero, 1);
    check(done == 1'b0 && busy == 1'b0, "R1", "no done/busy", {done, busy}, 0);
    @(negedge clk);
    check(div_zero == 1'b0, "R1", "div_zero one cycle", div_zero, 0);
    check(done == 1'b0, "R1", "no done later", done, 0);
    check(quotient == pq && remainder == pr, "R1", "results kept", {quotient, remainder}, {pq, pr});
    check(flags_out == pf, "R1", "flags kept", flags_out, pf);
  endtask

  task automatic test_start_ignored();
    logic [31:0] eq, er, hq;
    logic [4:0]  ef;
    int elat, k;
    model(1'b0, 32'h0000_0002, 32'h1234_5678, 32'h0000_0007, 5'h00, eq, er, ef, elat);
    drive_start(1'b0, 32'h0000_0002, 32'h1234_5678, 32'h0000_0007, 5'h00);
    hq = quotient;
    k = 0;
    repeat (4) begin @(negedge clk); k++; end
    signed_mode = 1'b1; dividend_hi = 32'h0; dividend_lo = 32'h5; divisor = 32'h3; start = 1'b1;
    @(negedge clk); k++;
    start = 1'b0;
    check(quotient == hq, "R10", "result held while busy", quotient, hq);
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    check(k == elat, "R10", "latency unaffected by start", k, elat);
    check(quotient == eq && remainder == er, "R10", "first operation result",
          {quotient, remainder}, {eq, er});
    repeat (3) @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10", "second start not taken", {done, busy}, 0);
    check(quotient == eq && remainder == er, "R10", "results stable", {quotient, remainder}, {eq, er});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    // unsigned loop path
    run_div("R2", 1'b0, 32'h0000_0001, 32'h0000_0000, 32'h0000_0003, 5'h00);
    run_div("R2", 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h8765_4321, 5'h10);
    run_div("R8", 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 5'h0F);
    run_div("R2", 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 5'h00);
    // zero dividend and short path
    run_div("R4", 1'b0, 32'h0, 32'h0, 32'h0000_0009, 5'h10);
    run_div("R4", 1'b1, 32'h0, 32'h0, 32'hFFFF_FFF0, 5'h00);
    run_div("R5", 1'b0, 32'h0, 32'h0000_0005, 32'h0000_0007, 5'h00);
    run_div("R5", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFB, 32'h0000_0007, 5'h00);
    // overflow by high word
    run_div("R6", 1'b0, 32'h0000_0005, 32'h0000_0001, 32'h0000_0005, 5'h1C);
    run_div("R6", 1'b1, 32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 5'h08);
    // signed sign restoration
    run_div("R3", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'h0000_0007, 5'h00);
    run_div("R3", 1'b1, 32'h0000_0000, 32'h0000_0064, 32'hFFFF_FFF9, 5'h10);
    run_div("R3", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'hFFFF_FFF9, 5'h00);
    run_div("R3", 1'b1, 32'hFFFF_FFF0, 32'h0000_0000, 32'h0000_0123, 5'h00);
    // signed quotient range
    run_div("R7", 1'b1, 32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 5'h14);
    run_div("R7", 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001, 5'h00);
    run_div("R7", 1'b1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0000_0001, 5'h00);
    test_zero_divisor();
    test_start_ignored();
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

endmodule